// File: doc/BRIEF.md
# Synthesiser Control Serial Slave

This block is the serial control front end of a frequency synthesiser. It sits on an I2C bus as a slave whose 7-bit address has a fixed five-bit prefix and two low bits taken from strap inputs, so more than one synthesiser can share the bus. A write carries frequency and control bytes. A read returns a status byte built from a power-on flag, the lock flag and a 3-bit converter code.

Each written byte names its own kind. When the slave is not waiting for the second byte of a pair, the MSB of the byte selects a frequency pair (0) or a control pair (1). Frequency bytes and the first control byte are collected in a shadow copy. The active divider ratio, prescaler enable and reference code are loaded from that copy in one step. This happens either when all 17 ratio bits have arrived in the current run of bytes, or at STOP. The second control byte takes effect as soon as it is received.

The active values drive the analogue core directly. A decoder turns the reference-output and test-select bits into output-routing, charge-pump and test controls.

Top module: `synth_ctl_slave`

## Requirements
- R1: The slave acknowledges an address byte equal to {5'b11000, addr_sel_i, R/W}, sent MSB first. It pulls SDA low for the acknowledge clock of that byte and of every written data byte after it.
- R2: After an address byte that does not match, the slave never pulls SDA and ignores every byte until the next START.
- R3: When no pair is open, a data byte with MSB 0 opens a frequency pair and a byte with MSB 1 opens a control pair. The byte after an opening byte is always the second byte of that pair. A START closes any open pair.
- R4: The first frequency byte supplies ratio bits 14..8 from its bits 6..0. The second frequency byte supplies ratio bits 7..0.
- R5: The first control byte supplies ratio bits 16..15 (bits 6..5), the prescaler enable (bit 4) and the reference code (bits 3..0). The second control byte supplies, from MSB to LSB: the charge-pump current (2 bits), RE, RTS and the ports P3..P0. refout_sel_o is 2'b00 when RE=0, 2'b01 when RE=1 and RTS=0, and 2'b10 when RE=1 and RTS=1.
- R6: Ratio, prescaler enable and reference code update together. This happens at the byte that completes the set {first frequency, second frequency, first control} received since the last update, or at STOP if any of those bytes is pending. They never change at any other time.
- R7: A byte cut short by STOP is discarded, and the bytes completed before it are still committed.
- R8: A read returns {POR, FL, 3'b000, adc_code_i} MSB first. Each master ACK makes the slave send another status byte.
- R9: After a master NACK in a read, the slave keeps SDA released until the next START.
- R10: The POR flag is set by reset and by por_evt_i, and is cleared by a STOP that ends a read. por_evt_i restores all registers to their reset values. port_hiz_o is high while the flag is set.
- R11: Test mode is RE=0 with RTS=1. In test mode, test select 010 gives charge-pump sink with FL read as 1, 011 gives source with FL 0, 100 turns the pump off with FL 0, 101 routes the divider output to P0, and 110 disables the drive. cp_mode_o encodes normal 00, sink 01, source 10, off 11.
- R12: A second control byte that selects test mode updates P3 and the test select, and leaves P2..P0 at their previous values.
- R13: After reset: ratio 0, prescaler off, reference code 0, pump current 0, RE=RTS=1 (refout_sel_o 2'b10), ports 0, test select 0, SDA released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Bus data line as seen on the wire |
| addr_sel_i | input | 2 | Strapped low address bits |
| por_evt_i | input | 1 | Supply-drop event; sets the POR flag and clears the registers |
| lock_i | input | 1 | Phase-lock flag from the detector |
| adc_code_i | input | 3 | Converter code reported in the status byte |
| ratio_o | output | 17 | Active divider ratio |
| presc_en_o | output | 1 | Active prescaler enable |
| ref_code_o | output | 4 | Active reference divider code |
| cp_cur_o | output | 2 | Active charge-pump current code |
| refout_sel_o | output | 2 | Reference output routing: off, reference, comparison |
| port_o | output | 4 | Active port bits P3..P0 |
| port_hiz_o | output | 1 | Ports released while the POR flag is set |
| test_sel_o | output | 3 | Active test select, zero outside test mode |
| cp_mode_o | output | 2 | Charge-pump mode |
| p0_div_o | output | 1 | Route divider output to P0 |
| drive_off_o | output | 1 | Varactor drive disabled |
| sda_pull_o | output | 1 | Open-drain pull-down for SDA |

## Verification
Every result depends on a bus edge passing through the two-stage line sampler and the edge register. The acknowledge pull and each read data bit therefore change three clock cycles after the SCL falling edge that requests them. A committed register changes one cycle after that. The bench moves SCL or SDA only every six clock cycles. It reads SDA half a bit after SCL rises, and it reads the register outputs no earlier than twelve cycles after the STOP or final byte that should update them. Every result is therefore settled before it is sampled. One check reads the registers between the last data byte and STOP, to show that nothing committed early.

// File: rtl/synth_ctl_pkg.sv
package synth_ctl_pkg;

   localparam int RATIO_W = 17;
   localparam int BYTE_W  = 8;

   typedef struct packed {
      logic [RATIO_W-1:0] ratio;
      logic               pe;
      logic [3:0]         ref_code;
   } freq_grp_t;

   typedef struct packed {
      logic [1:0] cp_cur;
      logic       re;
      logic       rts;
      logic [3:0] port;
      logic [2:0] tsel;
   } ctl_grp_t;

   typedef enum logic [2:0] {
      LK_IDLE, LK_ADDR, LK_ACK, LK_WDATA, LK_RDATA, LK_RACK, LK_SKIP
   } link_st_t;

   typedef enum logic [1:0] {
      CP_NORMAL = 2'b00, CP_SINK = 2'b01, CP_SOURCE = 2'b10, CP_OFF = 2'b11
   } cp_mode_t;

   typedef enum logic [1:0] {
      PEND_NONE, PEND_FREQ, PEND_CTRL
   } pend_t;

   localparam freq_grp_t FREQ_RST = '0;
   localparam ctl_grp_t  CTL_RST  = '{cp_cur: 2'b00, re: 1'b1, rts: 1'b1,
                                      port: 4'b0000, tsel: 3'b000};

endpackage

// File: rtl/i2c_link.sv
module i2c_link
   import synth_ctl_pkg::*;
#(
   parameter int         SYNC_STAGES = 2,
   parameter logic [4:0] ADDR_HI     = 5'b11000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_i,
   input  logic              sda_i,
   input  logic [1:0]        dev_sel_i,
   input  logic [BYTE_W-1:0] status_i,
   output logic              txn_start_o,
   output logic              byte_vld_o,
   output logic [BYTE_W-1:0] byte_o,
   output logic              stop_o,
   output logic              rd_stop_o,
   output logic              sda_pull_o
);

   localparam int CNT_W = $clog2(BYTE_W + 1);
   localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W);
   localparam logic [CNT_W-1:0] LAST_TX  = CNT_W'(BYTE_W - 1);

   logic [1:0] ln_s;

   generate
      if (SYNC_STAGES == 0) begin : g_nosync
         assign ln_s = {scl_i, sda_i};
      end else begin : g_sync
         logic [1:0] chain [SYNC_STAGES];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < SYNC_STAGES; i++) chain[i] <= 2'b11;
            end else begin
               chain[0] <= {scl_i, sda_i};
               for (int i = 1; i < SYNC_STAGES; i++) chain[i] <= chain[i-1];
            end
         end
         assign ln_s = chain[SYNC_STAGES-1];
      end
   endgenerate

   logic [1:0] ln_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ln_q <= 2'b11;
      else        ln_q <= ln_s;
   end

   logic scl, sda, scl_rise, scl_fall, start_det, stop_det;
   assign scl       = ln_s[1];
   assign sda       = ln_s[0];
   assign scl_rise  = scl & ~ln_q[1];
   assign scl_fall  = ~scl & ln_q[1];
   assign start_det = scl & ln_q[1] & ln_q[0] & ~sda;
   assign stop_det  = scl & ln_q[1] & ~ln_q[0] & sda;

   link_st_t          st;
   logic [CNT_W-1:0]  cnt;
   logic [BYTE_W-1:0] sh, tx;
   logic              rw, mack, rd_txn, pull;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st <= LK_IDLE; cnt <= '0; sh <= '0; tx <= '0;
         rw <= 1'b0; mack <= 1'b0; rd_txn <= 1'b0; pull <= 1'b0;
         txn_start_o <= 1'b0; byte_vld_o <= 1'b0; byte_o <= '0;
         stop_o <= 1'b0; rd_stop_o <= 1'b0;
      end else begin
         txn_start_o <= 1'b0;
         byte_vld_o  <= 1'b0;
         stop_o      <= 1'b0;
         rd_stop_o   <= 1'b0;
         if (start_det) begin
            st <= LK_ADDR; cnt <= '0; pull <= 1'b0;
            rd_txn <= 1'b0; txn_start_o <= 1'b1;
         end else if (stop_det) begin
            st <= LK_IDLE; pull <= 1'b0; stop_o <= 1'b1;
            rd_stop_o <= rd_txn; rd_txn <= 1'b0;
         end else begin
            case (st)
               LK_ADDR, LK_WDATA: begin
                  if (scl_rise && cnt < LAST_BIT) begin
                     sh  <= {sh[BYTE_W-2:0], sda};
                     cnt <= cnt + 1'b1;
                  end else if (scl_fall && cnt == LAST_BIT) begin
                     if (st == LK_ADDR) begin
                        if (sh[BYTE_W-1:1] == {ADDR_HI, dev_sel_i}) begin
                           st <= LK_ACK; pull <= 1'b1;
                           rw <= sh[0]; rd_txn <= sh[0];
                        end else begin
                           st <= LK_SKIP;
                        end
                     end else begin
                        st <= LK_ACK; pull <= 1'b1;
                        byte_vld_o <= 1'b1; byte_o <= sh;
                     end
                  end
               end
               LK_ACK: begin
                  if (scl_fall) begin
                     cnt <= '0;
                     if (rw) begin
                        tx <= status_i; pull <= ~status_i[BYTE_W-1];
                        st <= LK_RDATA;
                     end else begin
                        pull <= 1'b0; st <= LK_WDATA;
                     end
                  end
               end
               LK_RDATA: begin
                  if (scl_fall) begin
                     if (cnt == LAST_TX) begin
                        pull <= 1'b0; st <= LK_RACK;
                     end else begin
                        cnt  <= cnt + 1'b1;
                        tx   <= {tx[BYTE_W-2:0], 1'b0};
                        pull <= ~tx[BYTE_W-2];
                     end
                  end
               end
               LK_RACK: begin
                  if (scl_rise) begin
                     mack <= ~sda;
                  end else if (scl_fall) begin
                     if (mack) begin
                        tx <= status_i; pull <= ~status_i[BYTE_W-1];
                        cnt <= '0; st <= LK_RDATA;
                     end else begin
                        st <= LK_SKIP;
                     end
                  end
               end
               default: ;
            endcase
         end
      end
   end

   assign sda_pull_o = pull;

   // R9
   skip_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == LK_SKIP) |-> !sda_pull_o);

   // R2
   addr_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == LK_ADDR && scl_fall && cnt == LAST_BIT &&
       sh[BYTE_W-1:1] != {ADDR_HI, dev_sel_i}) |=> !sda_pull_o);

   // R8
   rack_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == LK_RACK) |-> !sda_pull_o);

endmodule

// File: rtl/synth_regs.sv
module synth_regs
   import synth_ctl_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              txn_start_i,
   input  logic              byte_vld_i,
   input  logic [BYTE_W-1:0] byte_i,
   input  logic              stop_i,
   input  logic              rd_stop_i,
   input  logic              por_evt_i,
   output freq_grp_t         act_f_o,
   output ctl_grp_t          act_c_o,
   output logic              por_o
);

   freq_grp_t sh_f, sh_n;
   pend_t     pend;
   logic      got_fa, got_fb, got_ca;
   logic      k_fa, k_fb, k_ca, k_cb;
   logic      fa_n, fb_n, ca_n, commit_f, test_req;

   always_comb begin
      k_fb = byte_vld_i && (pend == PEND_FREQ);
      k_cb = byte_vld_i && (pend == PEND_CTRL);
      k_fa = byte_vld_i && (pend == PEND_NONE) && !byte_i[BYTE_W-1];
      k_ca = byte_vld_i && (pend == PEND_NONE) &&  byte_i[BYTE_W-1];
      sh_n = sh_f;
      if (k_fa) sh_n.ratio[14:8] = byte_i[6:0];
      if (k_fb) sh_n.ratio[7:0]  = byte_i;
      if (k_ca) begin
         sh_n.ratio[RATIO_W-1:15] = byte_i[6:5];
         sh_n.pe                  = byte_i[4];
         sh_n.ref_code            = byte_i[3:0];
      end
      fa_n     = got_fa | k_fa;
      fb_n     = got_fb | k_fb;
      ca_n     = got_ca | k_ca;
      commit_f = (byte_vld_i && fa_n && fb_n && ca_n) ||
                 (stop_i && (got_fa || got_fb || got_ca));
      test_req = ~byte_i[5] & byte_i[4];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_f <= FREQ_RST; act_f_o <= FREQ_RST; act_c_o <= CTL_RST;
         pend <= PEND_NONE; got_fa <= 1'b0; got_fb <= 1'b0; got_ca <= 1'b0;
         por_o <= 1'b1;
      end else if (por_evt_i) begin
         sh_f <= FREQ_RST; act_f_o <= FREQ_RST; act_c_o <= CTL_RST;
         pend <= PEND_NONE; got_fa <= 1'b0; got_fb <= 1'b0; got_ca <= 1'b0;
         por_o <= 1'b1;
      end else begin
         sh_f <= sh_n;
         if (commit_f) begin
            act_f_o <= sh_n;
            got_fa <= 1'b0; got_fb <= 1'b0; got_ca <= 1'b0;
         end else begin
            got_fa <= fa_n; got_fb <= fb_n; got_ca <= ca_n;
         end
         if (k_cb) begin
            act_c_o.cp_cur  <= byte_i[7:6];
            act_c_o.re      <= byte_i[5];
            act_c_o.rts     <= byte_i[4];
            act_c_o.port[3] <= byte_i[3];
            if (test_req) begin
               act_c_o.tsel <= byte_i[2:0];
            end else begin
               act_c_o.port[2:0] <= byte_i[2:0];
               act_c_o.tsel      <= 3'b000;
            end
         end
         if (txn_start_i)      pend <= PEND_NONE;
         else if (k_fa)        pend <= PEND_FREQ;
         else if (k_ca)        pend <= PEND_CTRL;
         else if (k_fb || k_cb) pend <= PEND_NONE;
         if (rd_stop_i) por_o <= 1'b0;
      end
   end

   // R6
   freq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!byte_vld_i && !stop_i && !por_evt_i) |=> $stable(act_f_o));

   // R12
   test_port_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (k_cb && test_req && !por_evt_i) |=> (act_c_o.port[2:0] == $past(act_c_o.port[2:0])));

   // R10
   por_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      por_evt_i |=> (por_o && act_f_o == FREQ_RST && act_c_o == CTL_RST));

endmodule

// File: rtl/synth_test_dec.sv
module synth_test_dec
   import synth_ctl_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       re_i,
   input  logic       rts_i,
   input  logic [2:0] tsel_i,
   input  logic       lock_i,
   output cp_mode_t   cp_mode_o,
   output logic       p0_div_o,
   output logic       drive_off_o,
   output logic [1:0] refout_sel_o,
   output logic       fl_o
);

   logic test_on, fl_force, fl_val;
   assign test_on = ~re_i & rts_i;

   always_comb begin
      cp_mode_o   = CP_NORMAL;
      p0_div_o    = 1'b0;
      drive_off_o = 1'b0;
      fl_force    = 1'b0;
      fl_val      = 1'b0;
      if (test_on) begin
         case (tsel_i)
            3'b010: begin cp_mode_o = CP_SINK;   fl_force = 1'b1; fl_val = 1'b1; end
            3'b011: begin cp_mode_o = CP_SOURCE; fl_force = 1'b1; end
            3'b100: begin cp_mode_o = CP_OFF;    fl_force = 1'b1; end
            3'b101: p0_div_o    = 1'b1;
            3'b110: drive_off_o = 1'b1;
            default: ;
         endcase
      end
      refout_sel_o = re_i ? (rts_i ? 2'b10 : 2'b01) : 2'b00;
      fl_o         = fl_force ? fl_val : lock_i;
   end

   // R11
   normal_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (re_i || !rts_i) |-> (cp_mode_o == CP_NORMAL && !p0_div_o && !drive_off_o && fl_o == lock_i));

endmodule

// File: rtl/synth_ctl_slave.sv
module synth_ctl_slave
   import synth_ctl_pkg::*;
#(
   parameter int         SYNC_STAGES = 2,
   parameter logic [4:0] ADDR_HI     = 5'b11000
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               scl_i,
   input  logic               sda_i,
   input  logic [1:0]         addr_sel_i,
   input  logic               por_evt_i,
   input  logic               lock_i,
   input  logic [2:0]         adc_code_i,
   output logic [RATIO_W-1:0] ratio_o,
   output logic               presc_en_o,
   output logic [3:0]         ref_code_o,
   output logic [1:0]         cp_cur_o,
   output logic [1:0]         refout_sel_o,
   output logic [3:0]         port_o,
   output logic               port_hiz_o,
   output logic [2:0]         test_sel_o,
   output logic [1:0]         cp_mode_o,
   output logic               p0_div_o,
   output logic               drive_off_o,
   output logic               sda_pull_o
);

   generate
      if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
         $error("SYNC_STAGES must lie in 0..4");
      end
   endgenerate

   logic              txn_start, byte_vld, stop_evt, rd_stop, por_flag, fl;
   logic [BYTE_W-1:0] rx_byte, status;
   freq_grp_t         act_f;
   ctl_grp_t          act_c;
   cp_mode_t          cp_mode;

   assign status = {por_flag, fl, 3'b000, adc_code_i};

   i2c_link #(.SYNC_STAGES(SYNC_STAGES), .ADDR_HI(ADDR_HI)) u_link (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
      .dev_sel_i(addr_sel_i), .status_i(status),
      .txn_start_o(txn_start), .byte_vld_o(byte_vld), .byte_o(rx_byte),
      .stop_o(stop_evt), .rd_stop_o(rd_stop), .sda_pull_o(sda_pull_o)
   );

   synth_regs u_regs (
      .clk(clk), .rst_n(rst_n), .txn_start_i(txn_start),
      .byte_vld_i(byte_vld), .byte_i(rx_byte), .stop_i(stop_evt),
      .rd_stop_i(rd_stop), .por_evt_i(por_evt_i),
      .act_f_o(act_f), .act_c_o(act_c), .por_o(por_flag)
   );

   synth_test_dec u_dec (
      .clk(clk), .rst_n(rst_n), .re_i(act_c.re), .rts_i(act_c.rts),
      .tsel_i(act_c.tsel), .lock_i(lock_i),
      .cp_mode_o(cp_mode), .p0_div_o(p0_div_o), .drive_off_o(drive_off_o),
      .refout_sel_o(refout_sel_o), .fl_o(fl)
   );

   assign ratio_o    = act_f.ratio;
   assign presc_en_o = act_f.pe;
   assign ref_code_o = act_f.ref_code;
   assign cp_cur_o   = act_c.cp_cur;
   assign port_o     = act_c.port;
   assign test_sel_o = act_c.tsel;
   assign port_hiz_o = por_flag;
   assign cp_mode_o  = cp_mode;

endmodule

// File: tb/synth_ctl_slave_bench.sv
module synth_ctl_slave_bench;

   localparam int Q  = 6;
   localparam int WD = 150000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        scl = 1'b1, sda_m = 1'b1;
   logic [1:0]  addr_sel = 2'b10;
   logic        por_evt = 1'b0, lock = 1'b0;
   logic [2:0]  adc = 3'd0;
   wire         sda_line;
   logic [16:0] ratio;
   logic        pe, hiz, p0div, drvoff, pull;
   logic [3:0]  rcode, port;
   logic [1:0]  cpcur, rsel, cpmode;
   logic [2:0]  tsel;
   int          checks = 0, errors = 0;
   bit          done = 0;

   always #4 clk = ~clk;
   assign sda_line = sda_m & ~pull;

   synth_ctl_slave u_synth_ctl_slave (
      .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
      .addr_sel_i(addr_sel), .por_evt_i(por_evt), .lock_i(lock),
      .adc_code_i(adc), .ratio_o(ratio), .presc_en_o(pe), .ref_code_o(rcode),
      .cp_cur_o(cpcur), .refout_sel_o(rsel), .port_o(port), .port_hiz_o(hiz),
      .test_sel_o(tsel), .cp_mode_o(cpmode), .p0_div_o(p0div),
      .drive_off_o(drvoff), .sda_pull_o(pull)
   );

   typedef struct packed {
      logic [2:0]  n;
      logic [31:0] bytes;
      logic [16:0] ratio;
      logic        pe;
      logic [3:0]  rc;
      logic [1:0]  cp;
      logic [1:0]  rsel;
      logic [3:0]  port;
      logic [2:0]  tsel;
   } vec_t;

   localparam vec_t VEC [6] = '{
      '{3'd4, 32'h1234C58A, 17'h11234, 1'b0, 4'd5, 2'd2, 2'd0, 4'b1010, 3'd0},
      '{3'd2, 32'h05670000, 17'h10567, 1'b0, 4'd5, 2'd2, 2'd0, 4'b1010, 3'd0},
      '{3'd4, 32'hB34F7FFF, 17'h0FFFF, 1'b1, 4'd3, 2'd1, 2'd0, 4'b1111, 3'd0},
      '{3'd1, 32'h01000000, 17'h081FF, 1'b1, 4'd3, 2'd1, 2'd0, 4'b1111, 3'd0},
      '{3'd2, 32'h80550000, 17'h001FF, 1'b0, 4'd0, 2'd1, 2'd0, 4'b0111, 3'd5},
      '{3'd2, 32'h80200000, 17'h001FF, 1'b0, 4'd0, 2'd0, 2'd1, 4'b0000, 3'd0}
   };

   task automatic check(input string tag, input int act, input int exp_v);
      checks++;
      if (act != exp_v) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp_v);
      end
   endtask

   task automatic wq();
      repeat (Q) @(posedge clk);
      #1;
   endtask

   task automatic i2c_start();
      sda_m = 1'b1; wq(); scl = 1'b1; wq(); sda_m = 1'b0; wq(); scl = 1'b0; wq();
   endtask

   task automatic i2c_stop();
      sda_m = 1'b0; wq(); scl = 1'b1; wq(); sda_m = 1'b1; wq(); wq();
   endtask

   task automatic send_bit(input logic b);
      sda_m = b; wq(); scl = 1'b1; wq(); wq(); scl = 1'b0; wq();
   endtask

   task automatic get_bit(output logic b);
      sda_m = 1'b1; wq(); scl = 1'b1; wq(); b = sda_line; wq(); scl = 1'b0; wq();
   endtask

   task automatic send_byte(input logic [7:0] d, output logic ack);
      logic a;
      for (int i = 7; i >= 0; i--) send_bit(d[i]);
      get_bit(a);
      ack = ~a;
   endtask

   task automatic recv_byte(output logic [7:0] d, input logic mack);
      for (int i = 7; i >= 0; i--) get_bit(d[i]);
      send_bit(~mack);
   endtask

   initial begin
      repeat (WD) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL R13 watchdog actual=running expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic       ack;
      logic [7:0] rd;
      repeat (5) @(posedge clk);
      #1 rst_n = 1'b1;
      wq();
      // R13 reset state
      check("R13 ratio", ratio, 0);
      check("R13 refout_sel", rsel, 2);
      check("R13 port", port, 0);
      check("R13 ctl", {pe, rcode, cpcur, tsel}, 0);
      check("R13 sda", pull, 0);
      check("R10 hiz after reset", hiz, 1);

      // R8 read status, R9 NACK release, R10 POR clear
      lock = 1'b1; adc = 3'd5;
      i2c_start();
      send_byte(8'hC5, ack);
      check("R1 read addr ack", ack, 1);
      recv_byte(rd, 1'b1);
      check("R8 status first", rd, 8'hC5);
      recv_byte(rd, 1'b0);
      check("R8 status repeat", rd, 8'hC5);
      recv_byte(rd, 1'b0);
      check("R9 released after nack", rd, 8'hFF);
      i2c_stop();
      check("R10 hiz cleared by read stop", hiz, 0);
      i2c_start();
      send_byte(8'hC5, ack);
      recv_byte(rd, 1'b0);
      i2c_stop();
      check("R8 status por low", rd, 8'h45);

      // R3 R4 R5 R6 vector table
      for (int v = 0; v < 6; v++) begin
         i2c_start();
         send_byte(8'hC4, ack);
         check("R1 write addr ack", ack, 1);
         for (int b = 0; b < VEC[v].n; b++) begin
            send_byte(VEC[v].bytes[31-8*b -: 8], ack);
            check("R1 data ack", ack, 1);
         end
         i2c_stop();
         check("R4 R6 ratio", ratio, VEC[v].ratio);
         check("R5 pe/ref", {pe, rcode}, {VEC[v].pe, VEC[v].rc});
         check("R5 cp/refout", {cpcur, rsel}, {VEC[v].cp, VEC[v].rsel});
         check("R3 R12 port", port, VEC[v].port);
         check("R11 test sel", tsel, VEC[v].tsel);
         if (v == 4) check("R11 p0 div", {p0div, drvoff, cpmode}, 4'b1000);
      end

      // R2 address mismatch
      i2c_start();
      send_byte(8'hC0, ack);
      check("R2 no ack", ack, 0);
      send_byte(8'h00, ack);
      check("R2 data no ack", ack, 0);
      send_byte(8'h00, ack);
      i2c_stop();
      check("R2 ratio kept", ratio, 17'h001FF);

      // R6 no commit before STOP
      i2c_start();
      send_byte(8'hC4, ack);
      send_byte(8'h2A, ack);
      send_byte(8'h55, ack);
      wq(); wq();
      check("R6 held before stop", ratio, 17'h001FF);
      i2c_stop();
      check("R6 commit at stop", ratio, 17'h02A55);

      // R6 commit on 17 bits without STOP
      i2c_start();
      send_byte(8'hC4, ack);
      send_byte(8'h11, ack);
      send_byte(8'h22, ack);
      send_byte(8'hC2, ack);
      wq(); wq();
      check("R6 full set commit", ratio, 17'h11122);
      check("R6 ref with set", rcode, 2);
      send_byte(8'h27, ack);
      i2c_stop();
      check("R5 ports", port, 4'b0111);

      // R7 STOP inside a byte
      i2c_start();
      send_byte(8'hC4, ack);
      send_byte(8'h33, ack);
      send_bit(1'b1); send_bit(1'b0); send_bit(1'b1); send_bit(1'b0);
      i2c_stop();
      check("R7 partial dropped", ratio, 17'h13322);

      // R11 sink mode forces FL, R12 ports held
      i2c_start();
      send_byte(8'hC4, ack);
      send_byte(8'h80, ack);
      send_byte(8'h5A, ack);
      i2c_stop();
      check("R11 sink mode", cpmode, 2'b01);
      check("R12 p2..p0 held", port, 4'b1111);
      lock = 1'b0; adc = 3'd2;
      i2c_start();
      send_byte(8'hC5, ack);
      recv_byte(rd, 1'b0);
      i2c_stop();
      check("R11 fl forced", rd, 8'h42);

      i2c_start();
      send_byte(8'hC4, ack);
      send_byte(8'h80, ack);
      send_byte(8'h56, ack);
      i2c_stop();
      check("R11 drive off", {drvoff, p0div, cpmode}, 4'b1000);
      check("R12 p3 updated", port, 4'b0111);

      // R10 POR event
      @(posedge clk); #1 por_evt = 1'b1;
      @(posedge clk); #1 por_evt = 1'b0;
      wq();
      check("R10 ratio cleared", ratio, 0);
      check("R10 hiz set", hiz, 1);
      check("R10 refout default", rsel, 2);
      check("R10 ports cleared", port, 0);

      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule